// File: doc/BRIEF.md
# USB Hub Frame Timer

This block keeps the frame timing of a USB 2.0 hub. A free-running cycle counter marks out microframes of nominally 125 us. Every eighth microframe closes a 1 ms frame, which carries an 11-bit frame number that wraps modulo 2048. When full-speed or low-speed devices hang off the hub's downstream ports, a request pulse goes out at each frame boundary so that a start-of-frame packet can be sent to them. Encoding that packet is left to other logic.

In high-speed mode the hub follows the host. Each micro start-of-frame received on the upstream port is compared with the local counter phase. The reload length of the counter is then moved by one clock toward the host's cadence, never more, and it stays inside a band of ±TRIM clocks around nominal. The received frame number takes over the local numbering whenever it changes. If several expected arrivals go missing in a row, the timer keeps counting on its own period and raises a flag. In full-speed mode the strobe is ignored and the counter keeps its current period.

Top module: `usb_frame_timer`

## Requirements
- R1: During reset and right after it, `frame_num` and `uframe_num` read 0, and `sync_lost`, `uframe_tick`, `frame_tick` and `ds_sof_req` read 0. The microframe period starts at UF_CLKS.
- R2: `uframe_tick` pulses for one cycle once every P clocks, where P is the current microframe period. With no correction in between, P stays unchanged. In the cycle after each tick, `uframe_num` has advanced by 1 modulo 8.
- R3: `frame_tick` pulses together with the `uframe_tick` on which `uframe_num` reads 7. In the cycle after it, `uframe_num` reads 0 and `frame_num` has advanced by 1 modulo 2048 (2047 goes to 0).
- R4: `ds_sof_req` pulses exactly with `frame_tick` while `fs_attached` is 1, and stays 0 while `fs_attached` is 0.
- R5: While `hs_mode` is 0 (full-speed), `sof_valid` has no effect on the period or on the numbering.
- R6: While `hs_mode` is 1, the offset of a `sof_valid` cycle is the number of clocks since the microframe began (offset 0 is the cycle right after a tick). An offset of 0 leaves the period unchanged. An offset from 1 to P/2-1 (late) lengthens the period by one clock. An offset of P/2 or more (early) shortens it by one clock. The new period already governs the microframe in progress.
- R7: The period never leaves [UF_CLKS-TRIM, UF_CLKS+TRIM]. A correction that would cross a bound leaves it at the bound.
- R8: In high-speed mode, a strobe is new when it is the first accepted since reset or when its `sof_frame` differs from the previous accepted one. A new strobe that is exact or late sets `frame_num` to `sof_frame` and `uframe_num` to 0 in the next cycle.
- R9: A new strobe that arrives early makes the next `uframe_tick` a frame tick: `frame_num` reads `sof_frame`-1 and `uframe_num` reads 7 until that tick, and afterwards they read `sof_frame` and 0.
- R10: In high-speed mode, `sync_lost` rises in the cycle after the tick that ends the third consecutive microframe with no strobe. The counter keeps its period meanwhile. An accepted strobe clears the flag in the next cycle, and the flag is always 0 in full-speed mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_mode | input | 1 | 1 = high-speed, follow upstream strobes; 0 = full-speed, free-run |
| fs_attached | input | 1 | 1 when a full-speed or low-speed device is attached downstream |
| sof_valid | input | 1 | One-cycle strobe: micro start-of-frame received upstream |
| sof_frame | input | 11 | Frame number carried by the received strobe |
| uframe_tick | output | 1 | Pulse on the last cycle of each microframe |
| frame_tick | output | 1 | Pulse on the last cycle of each frame |
| ds_sof_req | output | 1 | Request to send a downstream start-of-frame |
| frame_num | output | 11 | Current frame number |
| uframe_num | output | 3 | Current microframe index within the frame |
| sync_lost | output | 1 | Upstream strobes missing |

## Verification
The hardest condition to reach from the ports is the moment when a new frame number arrives early. In that case the numbering must be pre-loaded one microframe behind, so that the coming tick turns the frame over. The stimulus places strobes at chosen offsets counted from each observed tick. The bench model tracks the expected period from those offsets, so every interval and every number can be predicted exactly. Directed runs drive the period into both clamps and cross the frame number from 2047 to 0. Random runs then mix late, exact, early and missing strobes.

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int UF_CLKS = 7500,
  parameter int TRIM    = UF_CLKS / 2000,
  parameter int LOSS_N  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hs_mode,
  input  logic        fs_attached,
  input  logic        sof_valid,
  input  logic [10:0] sof_frame,
  output logic        uframe_tick,
  output logic        frame_tick,
  output logic        ds_sof_req,
  output logic [10:0] frame_num,
  output logic [2:0]  uframe_num,
  output logic        sync_lost
);
  localparam int CW = $clog2(UF_CLKS + TRIM + 1);
  localparam int MW = $clog2(LOSS_N + 1);
  localparam logic [CW-1:0] PER_NOM = CW'(UF_CLKS);
  localparam logic [CW-1:0] PER_MIN = CW'(UF_CLKS - TRIM);
  localparam logic [CW-1:0] PER_MAX = CW'(UF_CLKS + TRIM);

  logic [CW-1:0] cnt, per;
  logic [2:0]    uf;
  logic [10:0]   fn, last_fn;
  logic          seen, got;
  logic [MW-1:0] miss;

  wire hit    = hs_mode & sof_valid;
  wire wrap   = cnt >= per - CW'(1);
  wire early  = cnt >= (per >> 1);
  wire late   = (cnt != '0) && !early;
  wire is_new = !seen || (sof_frame != last_fn);

  assign uframe_tick = wrap;
  assign frame_tick  = wrap && (uf == 3'd7);
  assign ds_sof_req  = frame_tick && fs_attached;
  assign frame_num   = fn;
  assign uframe_num  = uf;
  assign sync_lost   = (miss == MW'(LOSS_N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      per     <= PER_NOM;
      uf      <= '0;
      fn      <= '0;
      last_fn <= '0;
      seen    <= 1'b0;
      got     <= 1'b0;
      miss    <= '0;
    end else begin
      cnt <= wrap ? '0 : cnt + CW'(1);

      if (hit && early && per > PER_MIN)
        per <= per - CW'(1);
      else if (hit && late && per < PER_MAX)
        per <= per + CW'(1);

      if (hit && is_new) begin
        if (early && !wrap) begin
          fn <= sof_frame - 11'd1;
          uf <= 3'd7;
        end else begin
          fn <= sof_frame;
          uf <= 3'd0;
        end
      end else if (wrap) begin
        uf <= uf + 3'd1;
        if (uf == 3'd7) fn <= fn + 11'd1;
      end

      if (hit) begin
        last_fn <= sof_frame;
        seen    <= 1'b1;
      end

      if (!hs_mode) begin
        miss <= '0;
        got  <= 1'b0;
      end else if (hit) begin
        miss <= '0;
        got  <= !wrap;
      end else if (wrap) begin
        got <= 1'b0;
        if (!got && miss != MW'(LOSS_N)) miss <= miss + MW'(1);
      end
    end
  end
endmodule

// File: rtl/usb_frame_timer_chk.sv
module usb_frame_timer_chk #(
  parameter int UF_CLKS = 7500,
  parameter int TRIM    = UF_CLKS / 2000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        hs_mode,
  input logic        sof_valid,
  input logic        uframe_tick,
  input logic        ds_sof_req,
  input logic [10:0] frame_num,
  input logic [2:0]  uframe_num,
  input logic        sync_lost,
  input logic [$clog2(UF_CLKS + TRIM + 1)-1:0] per
);
  localparam int CW = $clog2(UF_CLKS + TRIM + 1);
  localparam int GW = CW + 1;

  logic [GW-1:0] gap;
  logic          armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap   <= '0;
      armed <= 1'b0;
    end else if (uframe_tick) begin
      gap   <= '0;
      armed <= 1'b1;
    end else begin
      gap <= gap + GW'(1);
    end
  end

  assert_uframe_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uframe_tick && !(hs_mode && sof_valid) |=> uframe_num == $past(uframe_num) + 3'd1);

  assert_frame_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uframe_tick && uframe_num == 3'd7 && !(hs_mode && sof_valid)
    |=> frame_num == $past(frame_num) + 11'd1);

  assert_sof_req_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ds_sof_req && !(hs_mode && sof_valid) |=> uframe_num == 3'd0);

  assert_fs_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_mode && sof_valid && !uframe_tick |=> $stable(frame_num) && $stable(uframe_num));

  assert_period_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_mode && sof_valid) |=> $stable(per));

  assert_period_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (per == $past(per)) || (per == $past(per) + CW'(1)) || (per + CW'(1) == $past(per)));

  assert_period_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
    per >= CW'(UF_CLKS - TRIM) && per <= CW'(UF_CLKS + TRIM));

  assert_tick_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uframe_tick && armed |-> gap + GW'(1) >= GW'(UF_CLKS - TRIM) && gap + GW'(1) <= GW'(UF_CLKS + TRIM));

  assert_sync_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hs_mode && sof_valid |=> !sync_lost);

  assert_sync_fs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_mode |=> !sync_lost);
endmodule

bind usb_frame_timer usb_frame_timer_chk #(.UF_CLKS(UF_CLKS), .TRIM(TRIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .sof_valid(sof_valid),
  .uframe_tick(uframe_tick), .ds_sof_req(ds_sof_req), .frame_num(frame_num),
  .uframe_num(uframe_num), .sync_lost(sync_lost), .per(per)
);

// File: tb/tb_usb_frame_timer.sv
module tb_usb_frame_timer;
  localparam int UF   = 64;
  localparam int TR   = 3;
  localparam int PMIN = UF - TR;
  localparam int PMAX = UF + TR;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hs_mode = 1'b0;
  logic        fs_attached = 1'b1;
  logic        sof_valid = 1'b0;
  logic [10:0] sof_frame = '0;
  logic        uframe_tick, frame_tick, ds_sof_req, sync_lost;
  logic [10:0] frame_num;
  logic [2:0]  uframe_num;

  always #5 clk = ~clk;

  usb_frame_timer #(.UF_CLKS(UF), .TRIM(TR), .LOSS_N(3)) dut (
    .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .fs_attached(fs_attached),
    .sof_valid(sof_valid), .sof_frame(sof_frame), .uframe_tick(uframe_tick),
    .frame_tick(frame_tick), .ds_sof_req(ds_sof_req), .frame_num(frame_num),
    .uframe_num(uframe_num), .sync_lost(sync_lost)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int exp_per = UF, exp_uf = 0, exp_fn = 0, last_f = 0;
  bit seen = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int next_per(input int p, input int d);
    if (d <= 1) return p;
    if (d - 1 >= p / 2) return (p - 1 < PMIN) ? PMIN : p - 1;
    return (p + 1 > PMAX) ? PMAX : p + 1;
  endfunction

  task automatic run(input int d, input int f, output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
      sof_valid = (d > 0 && c == d);
      sof_frame = 11'(f);
    end while (!uframe_tick);
    sof_valid = 1'b0;
  endtask

  task automatic step(input int d, input int f, input bit chk_int, input string req);
    int c, ef, eu, np;
    bit hit, isnew, early;
    hit   = hs_mode && d > 0;
    isnew = hit && (!seen || f != last_f);
    early = hit && (d - 1 >= exp_per / 2);
    np    = hit ? next_per(exp_per, d) : exp_per;
    run(d, f, c);
    if (chk_int) chk(req, "microframe interval", c, np);
    if (isnew) begin
      ef = early ? (f + 2047) % 2048 : f;
      eu = early ? 7 : 0;
    end else begin
      ef = exp_fn;
      eu = exp_uf;
    end
    chk(isnew ? (early ? "R9" : "R8") : "R2", "uframe_num", int'(uframe_num), eu);
    chk(isnew ? (early ? "R9" : "R8") : "R3", "frame_num", int'(frame_num), ef);
    chk("R3", "frame_tick", int'(frame_tick), int'(eu == 7));
    chk("R4", "ds_sof_req", int'(ds_sof_req), int'(eu == 7 && fs_attached));
    exp_per = np;
    exp_uf  = (eu + 1) % 8;
    exp_fn  = (eu == 7) ? (ef + 1) % 2048 : ef;
    if (hit) begin
      seen   = 1'b1;
      last_f = f;
    end
  endtask

  initial begin
    int r, d;
    repeat (3) @(negedge clk);
    chk("R1", "frame_num in reset", int'(frame_num), 0);
    chk("R1", "uframe_num in reset", int'(uframe_num), 0);
    chk("R1", "sync_lost in reset", int'(sync_lost), 0);
    chk("R1", "uframe_tick in reset", int'(uframe_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "frame_tick after reset", int'(frame_tick), 0);
    chk("R1", "ds_sof_req after reset", int'(ds_sof_req), 0);
    step(0, 0, 1'b0, "R2");
    repeat (16) step(0, 0, 1'b1, "R2");
    fs_attached = 1'b0;
    repeat (8) step(0, 0, 1'b1, "R4");
    fs_attached = 1'b1;
    step(3, 700, 1'b1, "R5");
    step(40, 701, 1'b1, "R5");

    hs_mode = 1'b1;
    step(3, 5, 1'b1, "R6");
    step(1, 5, 1'b1, "R6");
    step(61, 5, 1'b1, "R6");
    repeat (6) step(3, 5, 1'b1, "R7");
    repeat (8) step(58, 5, 1'b1, "R7");
    step(3, 2046, 1'b1, "R8");
    step(58, 2047, 1'b1, "R9");
    step(1, 2047, 1'b1, "R6");

    repeat (3) step(0, 2047, 1'b1, "R10");
    chk("R10", "sync_lost after two missing", int'(sync_lost), 0);
    step(0, 2047, 1'b1, "R10");
    chk("R10", "sync_lost after three missing", int'(sync_lost), 1);
    step(1, 2047, 1'b1, "R10");
    chk("R10", "sync_lost after strobe", int'(sync_lost), 0);

    r = int'($urandom(32'd1234));
    for (int i = 0; i < 80; i++) begin
      r = int'($urandom_range(0, 99));
      if (r < 20)      d = 0;
      else if (r < 55) d = int'($urandom_range(1, 5));
      else             d = int'($urandom_range(52, 58));
      step(d, 2047, 1'b1, "R6");
    end

    hs_mode = 1'b0;
    step(0, 0, 1'b1, "R2");
    step(0, 0, 1'b1, "R2");
    chk("R10", "sync_lost in full-speed", int'(sync_lost), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule